// File: doc/BRIEF.md
# 12-bit IQ Sample Byte Packer

The block turns one sample instant of parallel I/Q data, from up to two channels, into a stream of bytes. In dense mode each 12-bit I/Q pair takes three bytes, and the two components share the middle byte. In wide mode each 16-bit component is sent as two bytes, low byte first. At each sample instant the bytes of channel 0 go out first, then the bytes of channel 1. A channel that the enable mask switches off is left out of the stream.

A sample instant is taken on an `in_valid`/`in_ready` handshake, and the block stores it at that edge. `in_ready` then stays low until the last byte of that instant has been accepted on the `out_valid`/`out_ready` handshake. The sequencer has three states:
- **IDLE** waits for a sample. An accepted sample moves it to **EMIT_CH0** if channel 0 is enabled, to **EMIT_CH1** if only channel 1 is enabled, or leaves it in IDLE if the mask is 2'b00.
- **EMIT_CH0** sends the channel-0 bytes. After the last accepted byte it moves to EMIT_CH1 if channel 1 is enabled, otherwise back to IDLE.
- **EMIT_CH1** sends the channel-1 bytes and returns to IDLE after the last accepted byte.

Top module: `iq_byte_packer`

## Requirements
- R1: Out of reset, `out_valid` is 0 and `in_ready` is 1.
- R2: In dense mode (`width_sel` = 2'b10), the first byte of a channel's group is I[7:0].
- R3: In dense mode, the second byte holds Q[3:0] in bits 7:4 and I[11:8] in bits 3:0.
- R4: In dense mode, the third and last byte of the group is Q[11:4].
- R5: In wide mode (`width_sel` = 2'b00), a channel's group is four bytes in this order: I[7:0], I[15:8], Q[7:0], Q[15:8].
- R6: When both channels are enabled (`ch_en` = 2'b11; bit 0 is channel 0, bit 1 is channel 1), all bytes of channel 0 go out before any byte of channel 1 for the same sample instant.
- R7: A channel whose `ch_en` bit is 0 is skipped, so one enabled channel gives exactly 3 bytes in dense mode and 4 in wide mode.
- R8: A sample accepted with `ch_en` = 2'b00 produces no bytes, and `in_ready` is high again on the next cycle.
- R9: `in_ready` is low while `out_valid` is high. Input changes made after the sample was accepted do not change the bytes sent.
- R10: The width codes 2'b01 and 2'b11 produce the same byte stream as wide mode.
- R11: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_byte` does not change on the next cycle.
- R12: In dense mode, bits 15:12 of the I and Q inputs have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A sample instant is presented |
| in_ready | output | 1 | The block can accept a sample instant |
| ch0_i | input | 16 | Channel 0 in-phase word |
| ch0_q | input | 16 | Channel 0 quadrature word |
| ch1_i | input | 16 | Channel 1 in-phase word |
| ch1_q | input | 16 | Channel 1 quadrature word |
| ch_en | input | 2 | Channel enable mask, bit n enables channel n |
| width_sel | input | 2 | 2'b10 selects dense 12-bit, any other code selects 16-bit |
| out_valid | output | 1 | `out_byte` holds a valid byte |
| out_ready | input | 1 | The sink takes the byte |
| out_byte | output | 8 | Output byte |

## Verification
If the byte index or the state is wrong, bytes show up in the wrong order or at the wrong nibble positions. The scoreboard catches that on the first wrong handshake. If the sequencer leaves a state too early or too late, the stream loses or gains bytes, and the expected queue falls out of step at the next byte. A mask or width captured wrongly shows up within the same sample instant. A hold that breaks under backpressure is seen one cycle after a stalled byte.

// File: rtl/iqpk_pkg.sv
package iqpk_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_EMIT_CH0 = 2'd1,
        ST_EMIT_CH1 = 2'd2
    } pk_state_t;

    typedef enum logic {
        FMT_WIDE  = 1'b0,
        FMT_DENSE = 1'b1
    } pk_fmt_t;

    localparam logic [1:0] WSEL_DENSE = 2'b10;
    localparam int unsigned NUM_CH    = 2;
endpackage

// File: rtl/iqpk_capture.sv
module iqpk_capture
    import iqpk_pkg::*;
#(
    parameter int unsigned DW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [NUM_CH*DW-1:0] i_flat,
    input  logic [NUM_CH*DW-1:0] q_flat,
    input  logic [NUM_CH-1:0]    mask_in,
    input  logic [1:0]           wsel_in,
    output logic [NUM_CH*DW-1:0] i_held,
    output logic [NUM_CH*DW-1:0] q_held,
    output logic [NUM_CH-1:0]    mask_held,
    output pk_fmt_t              fmt_held
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                i_held[c*DW +: DW] <= '0;
                q_held[c*DW +: DW] <= '0;
            end else if (load) begin
                i_held[c*DW +: DW] <= i_flat[c*DW +: DW];
                q_held[c*DW +: DW] <= q_flat[c*DW +: DW];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_held <= '0;
            fmt_held  <= FMT_WIDE;
        end else if (load) begin
            mask_held <= mask_in;
            fmt_held  <= (wsel_in == WSEL_DENSE) ? FMT_DENSE : FMT_WIDE;
        end
    end
endmodule

// File: rtl/iqpk_seq.sv
module iqpk_seq
    import iqpk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [NUM_CH-1:0] mask_in,
    input  logic [NUM_CH-1:0] mask_held,
    input  pk_fmt_t           fmt_held,
    input  logic              out_ready,
    output logic              in_ready,
    output logic              out_valid,
    output logic              load,
    output logic              chan_sel,
    output logic [1:0]        byte_idx
);
    pk_state_t  state_q, state_d;
    logic [1:0] idx_q, idx_d;
    logic [1:0] last_idx;
    logic       group_done;

    assign last_idx   = (fmt_held == FMT_DENSE) ? 2'd2 : 2'd3;
    assign group_done = out_ready && (idx_q == last_idx);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_IDLE: begin
                idx_d = '0;
                if (in_valid) begin
                    if (mask_in[0])      state_d = ST_EMIT_CH0;
                    else if (mask_in[1]) state_d = ST_EMIT_CH1;
                end
            end
            ST_EMIT_CH0: begin
                if (group_done) begin
                    idx_d   = '0;
                    state_d = mask_held[1] ? ST_EMIT_CH1 : ST_IDLE;
                end else if (out_ready) begin
                    idx_d = idx_q + 2'd1;
                end
            end
            ST_EMIT_CH1: begin
                if (group_done) begin
                    idx_d   = '0;
                    state_d = ST_IDLE;
                end else if (out_ready) begin
                    idx_d = idx_q + 2'd1;
                end
            end
            default: begin
                state_d = ST_IDLE;
                idx_d   = '0;
            end
        endcase
    end

    always_comb begin
        in_ready  = (state_q == ST_IDLE);
        out_valid = (state_q == ST_EMIT_CH0) || (state_q == ST_EMIT_CH1);
        load      = in_ready && in_valid;
        chan_sel  = (state_q == ST_EMIT_CH1);
        byte_idx  = idx_q;
    end
endmodule

// File: rtl/iqpk_byte_mux.sv
module iqpk_byte_mux
    import iqpk_pkg::*;
#(
    parameter int unsigned DW = 16
) (
    input  logic [NUM_CH*DW-1:0] i_held,
    input  logic [NUM_CH*DW-1:0] q_held,
    input  pk_fmt_t              fmt,
    input  logic                 chan_sel,
    input  logic [1:0]           byte_idx,
    output logic [7:0]           byte_out
);
    logic [DW-1:0] i_w, q_w;

    assign i_w = chan_sel ? i_held[DW +: DW] : i_held[0 +: DW];
    assign q_w = chan_sel ? q_held[DW +: DW] : q_held[0 +: DW];

    always_comb begin
        byte_out = '0;
        if (fmt == FMT_DENSE) begin
            unique case (byte_idx)
                2'd0:    byte_out = i_w[7:0];
                2'd1:    byte_out = {q_w[3:0], i_w[11:8]};
                2'd2:    byte_out = q_w[11:4];
                default: byte_out = '0;
            endcase
        end else begin
            unique case (byte_idx)
                2'd0:    byte_out = i_w[7:0];
                2'd1:    byte_out = i_w[15:8];
                2'd2:    byte_out = q_w[7:0];
                default: byte_out = q_w[15:8];
            endcase
        end
    end
endmodule

// File: rtl/iq_byte_packer.sv
module iq_byte_packer
    import iqpk_pkg::*;
#(
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [DW-1:0] ch0_i,
    input  logic [DW-1:0] ch0_q,
    input  logic [DW-1:0] ch1_i,
    input  logic [DW-1:0] ch1_q,
    input  logic [1:0]    ch_en,
    input  logic [1:0]    width_sel,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [7:0]    out_byte
);
    logic [NUM_CH*DW-1:0] i_flat, q_flat, i_held, q_held;
    logic [NUM_CH-1:0]    mask_held;
    pk_fmt_t              fmt_held;
    logic                 load, chan_sel;
    logic [1:0]           byte_idx;

    assign i_flat = {ch1_i, ch0_i};
    assign q_flat = {ch1_q, ch0_q};

    iqpk_capture #(.DW(DW)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .i_flat    (i_flat),
        .q_flat    (q_flat),
        .mask_in   (ch_en),
        .wsel_in   (width_sel),
        .i_held    (i_held),
        .q_held    (q_held),
        .mask_held (mask_held),
        .fmt_held  (fmt_held)
    );

    iqpk_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .mask_in   (ch_en),
        .mask_held (mask_held),
        .fmt_held  (fmt_held),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .load      (load),
        .chan_sel  (chan_sel),
        .byte_idx  (byte_idx)
    );

    iqpk_byte_mux #(.DW(DW)) u_mux (
        .i_held   (i_held),
        .q_held   (q_held),
        .fmt      (fmt_held),
        .chan_sel (chan_sel),
        .byte_idx (byte_idx),
        .byte_out (out_byte)
    );
endmodule

// File: rtl/iqpk_checker.sv
module iqpk_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       in_ready,
    input logic       out_valid,
    input logic       out_ready,
    input logic [7:0] out_byte
);
    logic [3:0] burst_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)                        burst_cnt <= '0;
        else if (in_valid && in_ready)     burst_cnt <= '0;
        else if (out_valid && out_ready)   burst_cnt <= burst_cnt + 4'd1;
    end

    // R11: a stalled byte is held
    p_stall_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_byte)));

    // R9: no new sample while bytes are pending
    p_busy_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    // R1: the block is ready whenever no byte is pending
    p_idle_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready);

    // R9: ready comes back only after a byte handshake
    p_ready_return_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_ready) |-> $past(out_valid && out_ready));

    // R7: no instant yields more than two four-byte groups
    p_burst_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |-> (burst_cnt < 4'd8));
endmodule

bind iq_byte_packer iqpk_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_byte  (out_byte)
);

// File: tb/iq_byte_packer_tb.sv
`timescale 1ns/1ps
module iq_byte_packer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] ch0_i = '0, ch0_q = '0, ch1_i = '0, ch1_q = '0;
    logic [1:0]  ch_en = 2'b11;
    logic [1:0]  width_sel = 2'b10;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [7:0]  out_byte;

    int n_checks = 0;
    int n_fails  = 0;
    bit stall_on = 1'b0;
    bit done     = 1'b0;
    int cyc      = 0;

    typedef struct {
        logic [7:0] val;
        string      tag;
    } exp_t;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    iq_byte_packer u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .ch0_i     (ch0_i),
        .ch0_q     (ch0_q),
        .ch1_i     (ch1_i),
        .ch1_q     (ch1_q),
        .ch_en     (ch_en),
        .width_sel (width_sel),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_byte  (out_byte)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic void push_b(input logic [7:0] v, input string tag);
        exp_t e;
        e.val = v;
        e.tag = tag;
        exp_q.push_back(e);
    endfunction

    function automatic void push_group(input logic [15:0] i, input logic [15:0] q,
                                       input bit dense, input string tg);
        if (dense) begin
            push_b(i[7:0],            (tg != "") ? tg : "R2");
            push_b({q[3:0], i[11:8]}, (tg != "") ? tg : "R3");
            push_b(q[11:4],           (tg != "") ? tg : "R4");
        end else begin
            push_b(i[7:0],  (tg != "") ? tg : "R5");
            push_b(i[15:8], (tg != "") ? tg : "R5");
            push_b(q[7:0],  (tg != "") ? tg : "R5");
            push_b(q[15:8], (tg != "") ? tg : "R5");
        end
    endfunction

    task automatic send(input logic [15:0] i0, input logic [15:0] q0,
                        input logic [15:0] i1, input logic [15:0] q1,
                        input logic [1:0] en, input logic [1:0] ws, input string tg);
        bit dense;
        dense = (ws == 2'b10);
        if (en[0]) push_group(i0, q0, dense, tg);
        if (en[1]) push_group(i1, q1, dense, (tg != "") ? tg : "R6");
        @(negedge clk);
        ch0_i = i0; ch0_q = q0; ch1_i = i1; ch1_q = q1;
        ch_en = en; width_sel = ws; in_valid = 1'b1;
        forever begin
            #1;
            if (in_ready) break;
            @(negedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
        // R9: junk after acceptance must not reach the output
        ch0_i = $urandom; ch0_q = $urandom; ch1_i = $urandom; ch1_q = $urandom;
        ch_en = 2'($urandom); width_sel = 2'($urandom);
    endtask

    task automatic drain;
        int guard = 0;
        while ((exp_q.size() != 0 || out_valid) && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        repeat (3) @(negedge clk);
    endtask

    // sink readiness
    always @(negedge clk) begin
        out_ready <= stall_on ? (($urandom % 3) != 0) : 1'b1;
    end

    // monitor / scoreboard
    bit         prev_stall = 1'b0;
    logic [7:0] prev_byte  = '0;
    always begin
        @(negedge clk);
        #1;
        if (rst_n) begin
            if (prev_stall)
                check(out_valid && out_byte == prev_byte, "R11", {out_valid, out_byte}, {1'b1, prev_byte});
            if (out_valid)
                check(!in_ready, "R9", in_ready, 0);
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R7 extra byte", out_byte, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(out_byte == e.val, e.tag, out_byte, e.val);
                end
            end
            prev_stall = out_valid && !out_ready;
            prev_byte  = out_byte;
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            n_fails++;
            n_checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
        check(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(out_valid == 1'b0 && in_ready == 1'b1, "R1 after release", {out_valid, in_ready}, 2'b01);

        // R2 R3 R4 R6: dense, both channels
        send(16'h0ABC, 16'h0DEF, 16'h0123, 16'h0456, 2'b11, 2'b10, "");
        for (int k = 0; k < 6; k++)
            send(16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom), 2'b11, 2'b10, "");
        drain();

        // R5 R6: wide, both channels
        send(16'hA1B2, 16'hC3D4, 16'hE5F6, 16'h0718, 2'b11, 2'b00, "");
        for (int k = 0; k < 4; k++)
            send(16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom), 2'b11, 2'b00, "");
        drain();

        // R7: one channel at a time
        send(16'h0111, 16'h0222, 16'h0333, 16'h0444, 2'b01, 2'b10, "R7");
        send(16'h0555, 16'h0666, 16'h0777, 16'h0888, 2'b10, 2'b10, "R7");
        send(16'h1111, 16'h2222, 16'h3333, 16'h4444, 2'b01, 2'b00, "R7");
        send(16'h5555, 16'h6666, 16'h7777, 16'h8888, 2'b10, 2'b00, "R7");
        drain();

        // R8: empty mask
        send(16'hDEAD, 16'hBEEF, 16'hCAFE, 16'hF00D, 2'b00, 2'b10, "R8");
        #1;
        check(out_valid == 1'b0, "R8 no output", out_valid, 0);
        check(in_ready == 1'b1, "R8 ready", in_ready, 1);
        send(16'h0321, 16'h0654, 16'h0987, 16'h0CBA, 2'b11, 2'b10, "R8");
        drain();

        // R10: other width codes act as wide
        send(16'h1234, 16'h5678, 16'h9ABC, 16'hDEF0, 2'b11, 2'b01, "R10");
        send(16'hFEDC, 16'hBA98, 16'h7654, 16'h3210, 2'b11, 2'b11, "R10");
        drain();

        // R12: upper nibbles ignored in dense mode
        send(16'hF0A5, 16'hE05A, 16'hD0C3, 16'hB03C, 2'b11, 2'b10, "R12");
        drain();

        // R11: random backpressure
        stall_on = 1'b1;
        for (int k = 0; k < 20; k++)
            send(16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom),
                 2'(1 + ($urandom % 3)), (k % 2) ? 2'b10 : 2'b00, "R11");
        drain();
        stall_on = 1'b0;
        drain();

        check(exp_q.size() == 0, "R7 queue empty", exp_q.size(), 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule